// File: doc/BRIEF.md
# Register Rename Unit with Free Pool

This block maps architectural register numbers to physical register numbers for one instruction per cycle. It holds two map tables. The speculative map tracks the newest mapping seen by the rename stage. The committed map tracks the mappings of retired instructions. A bit-vector free pool records which physical registers can be handed out.

A renamed instruction presents two source register numbers and, optionally, a destination. The sources are looked up in the speculative map. A destination receives a fresh physical register from the free pool. The previous speculative mapping of that destination is returned so it can travel with the instruction to retirement.

At retirement, the commit port moves the committed map entry to the new physical register and returns the old one to the pool. No data is copied. A flush discards all speculative state: the speculative map is reloaded from the committed map, and the pool is rebuilt as every physical register the committed map does not name.

Top module: `reg_rename`

## Requirements
- R1: After reset both maps send architectural register i to physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are free.
- R2: `rn_psrc1`/`rn_psrc2` give the current speculative mapping of `rn_src1`/`rn_src2`, combinationally. They reflect every earlier accepted rename. A source equal to the same instruction's destination gets the mapping before that rename.
- R3: An accepted rename with `rn_has_dst=1` takes the lowest-numbered free physical register, returned on `rn_pdst` in the same cycle. `rn_pold` returns the destination's prior speculative mapping, and the speculative map is updated at the clock edge.
- R4: When no physical register is free and `rn_has_dst=1`, `rn_ready` is 0 and nothing is renamed.
- R5: A rename with `rn_has_dst=0` allocates nothing and leaves the speculative map unchanged. Outside a flush, `rn_ready` is 1 for it even when the pool is empty.
- R6: A commit (`cm_valid=1`) sets the committed map entry of `cm_arch` to `cm_new_phys`. It does not change the speculative map.
- R7: A commit returns `cm_old_phys` to the pool. That register can be allocated from the next cycle on, never in the cycle of the commit.
- R8: While `flush=1`, `rn_ready` is 0. At the edge, the speculative map takes the committed map (including a commit in the same cycle), and the pool becomes every register not named by the committed map.
- R9: A rename and a commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rn_valid | input | 1 | Rename request present |
| rn_ready | output | 1 | Rename can be accepted this cycle |
| rn_has_dst | input | 1 | Instruction writes a destination |
| rn_src1 | input | AW | First source architectural register |
| rn_src2 | input | AW | Second source architectural register |
| rn_dst | input | AW | Destination architectural register |
| rn_psrc1 | output | PW | Physical register of first source |
| rn_psrc2 | output | PW | Physical register of second source |
| rn_pdst | output | PW | Newly allocated physical register |
| rn_pold | output | PW | Previous speculative mapping of destination |
| cm_valid | input | 1 | An instruction retires |
| cm_arch | input | AW | Retiring destination architectural register |
| cm_new_phys | input | PW | Physical register holding the retired value |
| cm_old_phys | input | PW | Physical register that held the previous committed value |
| flush | input | 1 | Discard all speculative mappings |

## Verification
The bench first sweeps every architectural register as a source with no destination. This separates a correct identity reset map from a shifted or partial one, and shows that non-writing instructions consume nothing. It then renames every register as a destination until the pool runs dry, which exposes allocation order, old-mapping return and the stall. Commits issued into an empty pool show whether a freed register leaks into the same cycle. Flushes taken with a commit in flight, followed by a long pseudo-random mix of renames, commits and flushes, are compared against an arithmetic model of both maps and the pool. This catches stale restores and pool rebuild errors.

// File: rtl/rn_pkg.sv
// Shared defaults for the register rename unit.
package rn_pkg;
    localparam int unsigned RN_ARCH_REGS = 32;
    localparam int unsigned RN_PHYS_REGS = 64;
endpackage

// File: rtl/rn_spec_map.sv
// Speculative map table: one write port for the renamed destination and three
// combinational read ports (two sources, old destination mapping).
// Assumes restore and write are never asserted together by the caller.
module rn_spec_map #(
    parameter int unsigned NA = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned NP = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(NA),
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_arch,
    input  logic [PW-1:0]          wr_phys,
    input  logic                   restore,
    input  logic [NA-1:0][PW-1:0]  restore_map,
    input  logic [AW-1:0]          rd_a1,
    input  logic [AW-1:0]          rd_a2,
    input  logic [AW-1:0]          rd_a3,
    output logic [PW-1:0]          rd_p1,
    output logic [PW-1:0]          rd_p2,
    output logic [PW-1:0]          rd_p3
);
    logic [NA-1:0][PW-1:0] map_q;

    // Reset to identity, reload on restore, else write the renamed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NA); i++) map_q[i] <= PW'(i);
        end else if (restore) begin
            map_q <= restore_map;
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    // Combinational lookups of the current speculative state.
    always_comb begin
        rd_p1 = map_q[rd_a1];
        rd_p2 = map_q[rd_a2];
        rd_p3 = map_q[rd_a3];
    end
endmodule

// File: rtl/rn_commit_map.sv
// Committed map table: updated by retiring instructions. Exposes the
// next-state table so a flush in the same cycle sees the retiring entry.
module rn_commit_map #(
    parameter int unsigned NA = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned NP = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(NA),
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cm_en,
    input  logic [AW-1:0]          cm_arch,
    input  logic [PW-1:0]          cm_phys,
    output logic [NA-1:0][PW-1:0]  map_next
);
    logic [NA-1:0][PW-1:0] map_q;

    // Next table: current table with the retiring entry applied.
    always_comb begin
        map_next = map_q;
        if (cm_en) map_next[cm_arch] = cm_phys;
    end

    // Register the table, identity after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NA); i++) map_q[i] <= PW'(i);
        end else begin
            map_q <= map_next;
        end
    end
endmodule

// File: rtl/rn_free_list.sv
// Free pool as a bit vector, one bit per physical register. Allocation picks
// the lowest set bit of the registered vector, so a register returned this
// cycle becomes allocatable only next cycle. Rebuild marks free every register
// not named in the supplied map.
module rn_free_list #(
    parameter int unsigned NA = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned NP = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_en,
    input  logic                   ret_en,
    input  logic [PW-1:0]          ret_idx,
    input  logic                   rebuild,
    input  logic [NA-1:0][PW-1:0]  keep_map,
    output logic                   any_free,
    output logic [PW-1:0]          alloc_idx,
    output logic [NP-1:0]          free_vec
);
    logic [NP-1:0] free_q;
    logic [NP-1:0] used_by_map;

    // Lowest-index free register, scanning downward so the lowest wins.
    always_comb begin
        alloc_idx = '0;
        for (int i = int'(NP) - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_idx = PW'(i);
        end
    end

    // Registers named by the map used for a rebuild.
    always_comb begin
        used_by_map = '0;
        for (int a = 0; a < int'(NA); a++) used_by_map[keep_map[a]] = 1'b1;
    end

    // Update pool: reset, rebuild, or clear allocated and set returned bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NP); i++) free_q[i] <= (i >= int'(NA));
        end else if (rebuild) begin
            free_q <= ~used_by_map;
        end else begin
            if (alloc_en) free_q[alloc_idx] <= 1'b0;
            if (ret_en)   free_q[ret_idx]   <= 1'b1;
        end
    end

    assign any_free = |free_q;
    assign free_vec = free_q;
endmodule

// File: rtl/reg_rename.sv
// Register rename unit: speculative map, committed map and free pool.
// One rename and one commit per cycle. Assumes the caller commits in
// program order and that cm_old_phys is the committed mapping being replaced.
module reg_rename #(
    parameter int unsigned NUM_ARCH = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rn_valid,
    output logic          rn_ready,
    input  logic          rn_has_dst,
    input  logic [AW-1:0] rn_src1,
    input  logic [AW-1:0] rn_src2,
    input  logic [AW-1:0] rn_dst,
    output logic [PW-1:0] rn_psrc1,
    output logic [PW-1:0] rn_psrc2,
    output logic [PW-1:0] rn_pdst,
    output logic [PW-1:0] rn_pold,
    input  logic          cm_valid,
    input  logic [AW-1:0] cm_arch,
    input  logic [PW-1:0] cm_new_phys,
    input  logic [PW-1:0] cm_old_phys,
    input  logic          flush
);
    logic                       any_free;
    logic                       alloc;
    logic [NUM_PHYS-1:0]        free_vec;
    logic [NUM_ARCH-1:0][PW-1:0] comm_next;

    // Accept when not flushing and a register is free or none is needed.
    assign rn_ready = !flush && (any_free || !rn_has_dst);
    assign alloc    = rn_valid && rn_ready && rn_has_dst;

    rn_spec_map #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_smap (
        .clk(clk), .rst_n(rst_n),
        .wr_en(alloc), .wr_arch(rn_dst), .wr_phys(rn_pdst),
        .restore(flush), .restore_map(comm_next),
        .rd_a1(rn_src1), .rd_a2(rn_src2), .rd_a3(rn_dst),
        .rd_p1(rn_psrc1), .rd_p2(rn_psrc2), .rd_p3(rn_pold)
    );

    rn_commit_map #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_cmap (
        .clk(clk), .rst_n(rst_n),
        .cm_en(cm_valid), .cm_arch(cm_arch), .cm_phys(cm_new_phys),
        .map_next(comm_next)
    );

    rn_free_list #(.NA(NUM_ARCH), .NP(NUM_PHYS)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc), .ret_en(cm_valid), .ret_idx(cm_old_phys),
        .rebuild(flush), .keep_map(comm_next),
        .any_free(any_free), .alloc_idx(rn_pdst), .free_vec(free_vec)
    );
endmodule

// File: rtl/reg_rename_chk.sv
// Checker for the rename unit; attached to every reg_rename by bind.
module reg_rename_chk #(
    parameter int unsigned NUM_ARCH = rn_pkg::RN_ARCH_REGS,
    parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_REGS,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rn_valid,
    input logic                rn_ready,
    input logic                rn_has_dst,
    input logic [PW-1:0]       rn_pdst,
    input logic                cm_valid,
    input logic [PW-1:0]       cm_old_phys,
    input logic                flush,
    input logic [NUM_PHYS-1:0] free_vec
);
    // R3: the allocated register was free when handed out.
    a_r3_alloc_from_pool: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ready && rn_has_dst) |-> free_vec[rn_pdst]);

    // R3: the allocated register leaves the pool.
    a_r3_alloc_leaves_pool: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_ready && rn_has_dst) |=> !free_vec[$past(rn_pdst)]);

    // R4: no destination rename accepted while the pool is empty.
    a_r4_stall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec == '0 && rn_has_dst) |-> !rn_ready);

    // R7: a committed old register is in the pool next cycle.
    a_r7_old_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !flush) |=> free_vec[$past(cm_old_phys)]);

    // R8: no rename accepted during a flush.
    a_r8_ready_low_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rn_ready);

    // R8: after a flush exactly NUM_PHYS-NUM_ARCH registers are free.
    a_r8_pool_rebuilt: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(free_vec) == int'(NUM_PHYS - NUM_ARCH)));
endmodule

bind reg_rename reg_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_ready(rn_ready),
    .rn_has_dst(rn_has_dst), .rn_pdst(rn_pdst), .cm_valid(cm_valid),
    .cm_old_phys(cm_old_phys), .flush(flush), .free_vec(free_vec)
);

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
    localparam int NA = 32;
    localparam int NP = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rn_valid = 0, rn_has_dst = 0, cm_valid = 0, flush = 0;
    logic [4:0] rn_src1 = 0, rn_src2 = 0, rn_dst = 0, cm_arch = 0;
    logic [5:0] cm_new_phys = 0, cm_old_phys = 0;
    logic rn_ready;
    logic [5:0] rn_psrc1, rn_psrc2, rn_pdst, rn_pold;

    int checks = 0;
    int errors = 0;

    // Reference model
    int spec_m [NA];
    int comm_m [NA];
    bit free_m [NP];
    int q_arch [1024];
    int q_new  [1024];
    int q_old  [1024];
    int q_head = 0;
    int q_tail = 0;
    int lcg = 12345;

    always #4 clk = ~clk;

    reg_rename u_reg_rename (
        .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_ready(rn_ready),
        .rn_has_dst(rn_has_dst), .rn_src1(rn_src1), .rn_src2(rn_src2),
        .rn_dst(rn_dst), .rn_psrc1(rn_psrc1), .rn_psrc2(rn_psrc2),
        .rn_pdst(rn_pdst), .rn_pold(rn_pold), .cm_valid(cm_valid),
        .cm_arch(cm_arch), .cm_new_phys(cm_new_phys), .cm_old_phys(cm_old_phys),
        .flush(flush)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++) if (free_m[i]) return i;
        return -1;
    endfunction

    // One cycle: drive at negedge, check outputs, update model after the edge.
    task automatic step(input bit v, input bit hd, input int s1, input int s2,
                        input int d, input bit do_cm, input bit fl, input string tag);
        bit exp_rdy;
        bit cm_now;
        int lf;
        int c_arch, c_new, c_old;
        @(negedge clk);
        cm_now = do_cm && (q_head != q_tail);
        c_arch = cm_now ? q_arch[q_head] : 0;
        c_new  = cm_now ? q_new[q_head]  : 0;
        c_old  = cm_now ? q_old[q_head]  : 0;
        rn_valid = v; rn_has_dst = hd;
        rn_src1 = 5'(s1); rn_src2 = 5'(s2); rn_dst = 5'(d);
        cm_valid = cm_now; cm_arch = 5'(c_arch);
        cm_new_phys = 6'(c_new); cm_old_phys = 6'(c_old);
        flush = fl;
        #1;
        lf = lowest_free();
        exp_rdy = !fl && (!hd || lf >= 0);
        chk(tag, "rn_ready", int'(rn_ready), int'(exp_rdy));
        if (v && exp_rdy) begin
            chk(tag, "rn_psrc1", int'(rn_psrc1), spec_m[s1]);
            chk(tag, "rn_psrc2", int'(rn_psrc2), spec_m[s2]);
            if (hd) begin
                chk(tag, "rn_pdst", int'(rn_pdst), lf);
                chk(tag, "rn_pold", int'(rn_pold), spec_m[d]);
            end
        end
        @(posedge clk);
        if (cm_now) begin
            comm_m[c_arch] = c_new;
            q_head++;
        end
        if (fl) begin
            for (int i = 0; i < NP; i++) free_m[i] = 1'b1;
            for (int a = 0; a < NA; a++) begin
                spec_m[a] = comm_m[a];
                free_m[comm_m[a]] = 1'b0;
            end
            q_head = 0; q_tail = 0;
        end else begin
            if (v && exp_rdy && hd) begin
                q_arch[q_tail] = d; q_new[q_tail] = lf; q_old[q_tail] = spec_m[d];
                q_tail++;
                free_m[lf] = 1'b0;
                spec_m[d] = lf;
            end
            if (cm_now) free_m[c_old] = 1'b1;
        end
    endtask

    function automatic int rnd(input int m);
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >>> 8) % m;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) begin spec_m[a] = a; comm_m[a] = a; end
        for (int i = 0; i < NP; i++) free_m[i] = (i >= NA);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1, R5: identity lookups with no destination, pool untouched
        for (int i = 0; i < NA; i++) step(1, 0, i, NA - 1 - i, 0, 0, 0, "R1");
        // R3, R2: rename every register as a destination, source equals destination
        for (int i = 0; i < NA; i++) step(1, 1, i, (i + 5) % NA, i, 0, 0, "R3");
        // R2: newest mappings visible to later sources
        for (int i = 0; i < NA; i++) step(1, 0, i, (i * 7) % NA, 0, 0, 0, "R2");
        // R4: pool empty stalls a destination rename
        step(1, 1, 1, 2, 3, 0, 0, "R4");
        step(1, 1, 4, 5, 6, 0, 0, "R4");
        // R5: no-destination rename still accepted while empty
        step(1, 0, 7, 8, 0, 0, 0, "R5");
        // R7: commit into empty pool; freed register not reissued in that cycle
        step(1, 1, 3, 4, 7, 1, 0, "R7");
        step(1, 1, 3, 4, 7, 0, 0, "R7");
        step(1, 1, 9, 9, 9, 0, 0, "R4");
        // R9: rename and commit in the same cycle
        for (int i = 0; i < 20; i++) step(1, 1, i, i + 1, (i * 3) % NA, 1, 0, "R9");
        // R8: flush with a commit in the same cycle
        step(1, 1, 0, 0, 0, 1, 1, "R8");
        // R6: sources now see the committed map
        for (int i = 0; i < NA; i++) step(1, 0, i, (i + 11) % NA, 0, 0, 0, "R6");
        // R8: allocations after the rebuild
        for (int i = 0; i < 40; i++) step(1, 1, i % NA, 3, (i * 5) % NA, i[0], 0, "R8");
        // R9: pseudo-random mix of renames, commits and occasional flushes
        for (int i = 0; i < 600; i++)
            step(rnd(4) != 0, rnd(3) != 0, rnd(NA), rnd(NA), rnd(NA),
                 rnd(3) != 0, rnd(50) == 0, "R9");

        @(negedge clk);
        rn_valid = 0; cm_valid = 0; flush = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule